// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the master side of a link to a serial analog-to-digital converter. A one-cycle trigger, or a trigger held high, starts a transaction. The block then pulls the converter's active-low select low. It derives a serial clock from the system clock by a fixed division, and that clock idles high. For a fixed number of request clocks no data is expected. After that, the converter's response frame is shifted in one bit per serial clock.

The converter changes its output bit on each falling serial clock edge. The reader samples that bit in the system clock cycle where the serial clock goes high again, which is midway between two converter updates. The frame is 16 bits, most significant bit first: a zero guard bit, then the 12-bit sample, then three zero guard bits. When the last bit arrives, the select returns high and the sample is presented on a parallel output. A one-cycle valid strobe goes with it, and so does an error flag that is set when any guard bit is not zero.

A companion converter shares the serial clock and the master data line. Its select is held idle and the master data line is held low for the whole time this block runs. Between transactions the select stays high for a minimum gap before the next transaction, and the trigger can stay high for back-to-back reads.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, adc_cs_n and sclk are 1, while sample_valid, frame_err and busy are 0 and sample is 0.
- R2: When start is 1 and busy is 0, adc_cs_n is 0 after the next clock edge. Whenever adc_cs_n is 1, sclk is 1.
- R3: A transaction holds adc_cs_n low for exactly (REQ_CLKS+FRAME_BITS)*SCLK_DIV clock cycles. Within that time sclk makes exactly REQ_CLKS+FRAME_BITS falling edges, each SCLK_DIV cycles apart.
- R4: adc_miso is sampled as sclk rises. The last FRAME_BITS samples form the frame, first sample as MSB, and the bits before them are ignored. sample equals frame bits [14:3], which are the SAMPLE_BITS bits below the single leading bit.
- R5: sample_valid is high for exactly one cycle per transaction, and it is the first cycle in which adc_cs_n is high again.
- R6: frame_err is set together with sample_valid when frame bit 15 (the leading bit) or any of frame bits [2:0] (the trailing bits) is 1. sample and frame_err hold their values until the next sample_valid.
- R7: After a transaction, adc_cs_n stays high for at least GAP_SCLKS*SCLK_DIV cycles. If start is held high, the next transaction begins after exactly that many cycles.
- R8: start is ignored while busy is 1. This covers the whole transfer and all gap cycles except the last one, where start begins the next transaction.
- R9: aux_cs_n stays 1 and mosi stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion trigger |
| adc_miso | input | 1 | Converter serial data output |
| adc_cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Shared serial clock, idles high |
| mosi | output | 1 | Shared master data line, held low |
| aux_cs_n | output | 1 | Companion converter select, held idle |
| sample | output | SAMPLE_BITS | Last extracted sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| frame_err | output | 1 | A guard bit of the last frame was not zero |
| busy | output | 1 | Transaction or gap in progress |

## Verification
A sample sweep over the 12-bit range in steps of 13 is run, together with walking-one and walking-zero patterns. These show up any wrong bit order, a shift that is off by one, or request-phase bits that leak into the sample. Every combination of the leading and trailing guard bits is run around a fixed sample, which shows whether each guard bit separately raises the error while the sample stays intact. Trigger pulses are injected during the transfer and early in the gap, and a run with the trigger held high checks that the gap is exact. Both show whether the design restarts too early or drops a back-to-back transaction.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d     = gen_q;
        rise_tick = 1'b0;
        if (!run) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b1;
        end else if (gen_q.cnt == CW'(DIV - 1)) begin
            // end of period: the serial clock goes high, data is taken now
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b1;
            rise_tick  = 1'b1;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
            if (gen_q.cnt == CW'(HALF - 1)) begin
                gen_d.sclk = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q.cnt  <= '0;
            gen_q.sclk <= 1'b1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk = gen_q.sclk;
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic                  miso,
    output logic [FRAME_BITS-1:0] frame_next
);
    logic [FRAME_BITS-1:0] shreg_d, shreg_q;

    // bits from the request phase fall off the top before the frame ends
    assign frame_next = {shreg_q[FRAME_BITS-2:0], miso};

    always_comb begin
        shreg_d = shreg_q;
        if (shift_en) begin
            shreg_d = frame_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= shreg_d;
        end
    end
endmodule

// File: rtl/adcrd_extract.sv
module adcrd_extract #(
    parameter int FRAME_BITS  = 16,
    parameter int SAMPLE_BITS = 12,
    parameter int LEAD_BITS   = 1
) (
    input  logic [FRAME_BITS-1:0]  frame,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   bad
);
    localparam int TRAIL_BITS = FRAME_BITS - LEAD_BITS - SAMPLE_BITS;

    logic lead_bad, trail_bad;

    assign sample = frame[FRAME_BITS-LEAD_BITS-1 -: SAMPLE_BITS];

    generate
        if (LEAD_BITS > 0) begin : g_lead
            assign lead_bad = |frame[FRAME_BITS-1 -: LEAD_BITS];
        end else begin : g_nolead
            assign lead_bad = 1'b0;
        end
        if (TRAIL_BITS > 0) begin : g_trail
            assign trail_bad = |frame[TRAIL_BITS-1:0];
        end else begin : g_notrail
            assign trail_bad = 1'b0;
        end
    endgenerate

    assign bad = lead_bad | trail_bad;
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int TOTAL_CLKS  = 24,
    parameter int GAP_CYC     = 32,
    parameter int SAMPLE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   rise_tick,
    input  logic [SAMPLE_BITS-1:0] sample_in,
    input  logic                   bad_in,
    output logic                   run,
    output logic                   busy,
    output logic                   cs_n,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   valid,
    output logic                   err
);
    localparam int BW = $clog2(TOTAL_CLKS + 1);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        rd_state_e              state;
        logic [BW-1:0]          bitc;
        logic [GW-1:0]          gapc;
        logic                   cs_n;
        logic [SAMPLE_BITS-1:0] sample;
        logic                   valid;
        logic                   err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.bitc  = '0;
                end
            end
            ST_XFER: begin
                if (rise_tick) begin
                    if (ctl_q.bitc == BW'(TOTAL_CLKS - 1)) begin
                        ctl_d.state  = ST_GAP;
                        ctl_d.cs_n   = 1'b1;
                        ctl_d.gapc   = '0;
                        ctl_d.valid  = 1'b1;
                        ctl_d.sample = sample_in;
                        ctl_d.err    = bad_in;
                    end else begin
                        ctl_d.bitc = ctl_q.bitc + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (ctl_q.gapc == GW'(GAP_CYC - 1)) begin
                    if (start) begin
                        ctl_d.state = ST_XFER;
                        ctl_d.cs_n  = 1'b0;
                        ctl_d.bitc  = '0;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end else begin
                    ctl_d.gapc = ctl_q.gapc + 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.bitc   <= '0;
            ctl_q.gapc   <= '0;
            ctl_q.cs_n   <= 1'b1;
            ctl_q.sample <= '0;
            ctl_q.valid  <= 1'b0;
            ctl_q.err    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run    = (ctl_q.state == ST_XFER);
    assign busy   = (ctl_q.state != ST_IDLE);
    assign cs_n   = ctl_q.cs_n;
    assign sample = ctl_q.sample;
    assign valid  = ctl_q.valid;
    assign err    = ctl_q.err;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int SCLK_DIV    = 16,
    parameter int REQ_CLKS    = 8,
    parameter int FRAME_BITS  = 16,
    parameter int SAMPLE_BITS = 12,
    parameter int LEAD_BITS   = 1,
    parameter int GAP_SCLKS   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   adc_miso,
    output logic                   adc_cs_n,
    output logic                   sclk,
    output logic                   mosi,
    output logic                   aux_cs_n,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   sample_valid,
    output logic                   frame_err,
    output logic                   busy
);
    localparam int TOTAL_CLKS = REQ_CLKS + FRAME_BITS;
    localparam int GAP_CYC    = GAP_SCLKS * SCLK_DIV;

    logic                   run;
    logic                   rise_tick;
    logic [FRAME_BITS-1:0]  frame_next;
    logic [SAMPLE_BITS-1:0] sample_w;
    logic                   bad_w;

    adcrd_sclk_gen #(.DIV(SCLK_DIV)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .sclk      (sclk),
        .rise_tick (rise_tick)
    );

    adcrd_capture #(.FRAME_BITS(FRAME_BITS)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (rise_tick),
        .miso       (adc_miso),
        .frame_next (frame_next)
    );

    adcrd_extract #(
        .FRAME_BITS  (FRAME_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .LEAD_BITS   (LEAD_BITS)
    ) u_ext (
        .frame  (frame_next),
        .sample (sample_w),
        .bad    (bad_w)
    );

    adcrd_ctrl #(
        .TOTAL_CLKS  (TOTAL_CLKS),
        .GAP_CYC     (GAP_CYC),
        .SAMPLE_BITS (SAMPLE_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rise_tick (rise_tick),
        .sample_in (sample_w),
        .bad_in    (bad_w),
        .run       (run),
        .busy      (busy),
        .cs_n      (adc_cs_n),
        .sample    (sample),
        .valid     (sample_valid),
        .err       (frame_err)
    );

    // shared lines: no command data is sent, companion stays deselected
    assign mosi     = 1'b0;
    assign aux_cs_n = 1'b1;
endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker #(
    parameter int XFER_CYC    = 384,
    parameter int GAP_CYC     = 32,
    parameter int SAMPLE_BITS = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   adc_cs_n,
    input logic                   sclk,
    input logic                   sample_valid,
    input logic                   frame_err,
    input logic [SAMPLE_BITS-1:0] sample
);
    logic [15:0] lo_cnt, hi_cnt;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            seen_q <= 1'b0;
        end else if (adc_cs_n) begin
            lo_cnt <= '0;
            if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            seen_q <= 1'b1;
            if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> sclk);
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !adc_cs_n);
    p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (lo_cnt == 16'(XFER_CYC)));
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    p_valid_edge_r5: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $rose(adc_cs_n));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> ($stable(sample) && $stable(frame_err)));
    p_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_cs_n) && seen_q) |-> (hi_cnt >= 16'(GAP_CYC)));
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && start) |=> (!adc_cs_n || sample_valid));
endmodule

bind adc_frame_reader adcrd_checker #(
    .XFER_CYC    ((REQ_CLKS + FRAME_BITS) * SCLK_DIV),
    .GAP_CYC     (GAP_SCLKS * SCLK_DIV),
    .SAMPLE_BITS (SAMPLE_BITS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .adc_cs_n     (adc_cs_n),
    .sclk         (sclk),
    .sample_valid (sample_valid),
    .frame_err    (frame_err),
    .sample       (sample)
);

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;
    localparam int DIV      = 4;
    localparam int REQ      = 8;
    localparam int TOTAL    = 24;
    localparam int XFER_CYC = TOTAL * DIV;
    localparam int GAP_CYC  = 2 * DIV;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
    logic        cs_n, sclk, mosi, aux_cs_n, sample_valid, frame_err, busy;
    logic [11:0] sample;
    logic [15:0] cur_frame = 16'h0;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    int frames_started = 0, last_gap = 0;

    adc_frame_reader #(.SCLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .adc_miso(miso),
        .adc_cs_n(cs_n), .sclk(sclk), .mosi(mosi), .aux_cs_n(aux_cs_n),
        .sample(sample), .sample_valid(sample_valid),
        .frame_err(frame_err), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model: new bit on each falling serial clock edge
    initial begin
        forever begin
            logic [15:0] fr;
            @(negedge cs_n);
            fr = cur_frame;
            for (int k = 1; k <= TOTAL; k++) begin
                @(negedge sclk);
                miso = (k > REQ) ? fr[TOTAL-k] : 1'b0;
            end
        end
    end

    // timing monitor: select length, edge count, gap, shared lines
    logic prev_cs = 1'b1, prev_sclk = 1'b1, seen_rise = 1'b0;
    int   lo_len = 0, hi_len = 0, falls = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n) begin
                if (!prev_cs) begin
                    mon_checks += 3;
                    if (lo_len != XFER_CYC) begin
                        mon_fails++;
                        $display("FAIL R3 select low actual=%0d expected=%0d", lo_len, XFER_CYC);
                    end
                    if (falls != TOTAL) begin
                        mon_fails++;
                        $display("FAIL R3 sclk falls actual=%0d expected=%0d", falls, TOTAL);
                    end
                    if (!sclk) begin
                        mon_fails++;
                        $display("FAIL R2 sclk idle actual=%0d expected=1", sclk);
                    end
                    seen_rise = 1'b1;
                    lo_len = 0;
                end
                hi_len++;
            end else begin
                if (prev_cs) begin
                    frames_started++;
                    last_gap = hi_len;
                    mon_checks += 2;
                    if (seen_rise && hi_len < GAP_CYC) begin
                        mon_fails++;
                        $display("FAIL R7 gap actual=%0d expected>=%0d", hi_len, GAP_CYC);
                    end
                    if (!aux_cs_n || mosi) begin
                        mon_fails++;
                        $display("FAIL R9 aux/mosi actual=%0d expected=2", {aux_cs_n, mosi});
                    end
                    hi_len = 0;
                    falls = 0;
                end
                lo_len++;
                if (prev_sclk && !sclk) falls++;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic wait_valid(input logic [15:0] fr, input string tag);
        int n = 0;
        logic [11:0] exp_s;
        logic        exp_e;
        exp_s = fr[14:3];
        exp_e = fr[15] | (|fr[2:0]);
        while (!sample_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(sample_valid, "R5 valid seen", int'(sample_valid), 1);
        chk(sample == exp_s, {tag, " R4 sample"}, int'(sample), int'(exp_s));
        chk(frame_err == exp_e, {tag, " R6 err"}, int'(frame_err), int'(exp_e));
        @(negedge clk);
        chk(!sample_valid, "R5 one-cycle valid", int'(sample_valid), 0);
        chk(sample == exp_s && frame_err == exp_e, "R6 hold", int'(sample), int'(exp_s));
    endtask

    task automatic run_one(input logic [15:0] fr, input string tag);
        cur_frame = fr;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n, "R2 select falls", int'(cs_n), 0);
        wait_valid(fr, tag);
        repeat (GAP_CYC + 2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        int f0;
        repeat (5) @(negedge clk);
        chk(cs_n && sclk && !sample_valid && !frame_err && !busy && sample == 0,
            "R1 reset", int'({cs_n, sclk, sample_valid, frame_err, busy}), 24);
        chk(aux_cs_n && !mosi, "R9 reset", int'({aux_cs_n, mosi}), 2);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !busy, "R1 idle", int'({cs_n, sclk, busy}), 6);

        // sample sweep (R4)
        for (int v = 0; v < 4096; v += 13) run_one({1'b0, 12'(v), 3'b000}, "sweep");
        run_one({1'b0, 12'hFFF, 3'b000}, "full");
        for (int b = 0; b < 12; b++) begin
            run_one({1'b0, 12'(1 << b), 3'b000}, "walk1");
            run_one({1'b0, ~12'(1 << b), 3'b000}, "walk0");
        end

        // guard bit errors (R6)
        for (int l = 0; l < 2; l++)
            for (int t = 0; t < 8; t++)
                run_one({1'(l), 12'hA5C, 3'(t)}, "guard");

        // start during transfer and early gap (R8)
        f0 = frames_started;
        cur_frame = {1'b0, 12'h3C5, 3'b000};
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_valid(cur_frame, "R8 mid");
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (GAP_CYC + 20) @(negedge clk);
        chk(frames_started == f0 + 1, "R8 ignored start", frames_started - f0, 1);
        chk(cs_n && !busy, "R8 idle after", int'({cs_n, busy}), 2);

        // back-to-back with start held (R7)
        f0 = frames_started;
        cur_frame = 16'h0F78;
        @(negedge clk); start = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic [15:0] fr;
            fr = cur_frame;
            wait_valid(fr, "R7 b2b");
            cur_frame = {1'b0, 12'(i * 701 + 5), 3'b000};
            if (i == 5) start = 1'b0;
        end
        repeat (XFER_CYC + GAP_CYC) @(negedge clk);
        chk(last_gap == GAP_CYC, "R7 exact gap", last_gap, GAP_CYC);
        chk(frames_started == f0 + 6, "R7 frame count", frames_started - f0, 6);
        chk(aux_cs_n && !mosi, "R9 end", int'({aux_cs_n, mosi}), 2);

        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end
endmodule